// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event status, interrupt-enable and DMA-enable state of a bus-master serial controller. A transfer engine reports events by raising one-cycle set pulses on a 16-bit event vector; each pulse latches the matching status bit. The unit combines status with the enable mask to drive a single interrupt line, and gates the receive-ready and transmit-ready flags with the two DMA-enable bits to form the receive and transmit DMA requests.

Software reaches the state over a simple single-cycle register port. A register is picked with a 3-bit select, and read data is combinational from the stored state, so it is valid in the same cycle as the read strobe. There is no back-pressure: every access finishes in the cycle it is presented. A parameter chooses between a legacy behaviour and a newer one. In legacy mode, software acknowledges events by reading a vector register, and the status register cannot be written. In newer mode, the vector register is inert, and status is cleared by writing ones.

Top module: `intr_status_unit`

## Requirements
- R1: A synchronous active-high reset clears status, enable and DMA-enable. After it, every register reads zero and the interrupt and both DMA requests are low.
- R2: The interrupt line is high exactly when some bit is set both in status and in the enable mask.
- R3: Register select 0 reads the status word, with bit 12 replaced by the `line_busy` input.
- R4: A set pulse on `evt_set` bit i sets status bit i on the next clock edge. Bit 12 of `evt_set` is ignored. A set pulse wins over a clear of the same bit in the same cycle.
- R5: In newer mode, writing status (select 0) clears the bits in positions 0, 1, 2 and 5 that are written as one. Bits 3 (receive ready) and 4 (transmit ready), and every other bit, are unaffected. In legacy mode, status writes have no effect.
- R6: Select 1 writes and reads the enable mask. It keeps the low 6 bits in newer mode and the low 5 bits in legacy mode; higher written bits are dropped.
- R7: Select 3 is the DMA-enable register. Only bit 15 (receive) and bit 7 (transmit) are stored. Writing it with bit 15 set clears enable bit 3, and writing it with bit 7 set clears enable bit 4.
- R8: The receive DMA request equals status bit 3 AND DMA-enable bit 15. The transmit DMA request equals status bit 4 AND DMA-enable bit 7.
- R9: In legacy mode, a read of select 2 returns the 1-based position of the lowest bit set in status AND enable, or 0 if there is none, and clears that status bit at the clock edge. In newer mode, select 2 reads 0 and the read changes nothing.
- R10: In newer mode, a write to select 4 with bit 11 set forces status bits 5 to 0 high. In legacy mode that write has no effect. Select 4, and any unused select, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on select 2) |
| bus_sel | input | 3 | Register select: 0 status, 1 enable, 2 vector, 3 DMA-enable, 4 test |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for the selected register |
| evt_set | input | 16 | One-cycle event set pulses from the transfer engine |
| line_busy | input | 1 | Serial line busy flag, reported in status bit 12 |
| irq_o | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
All 64 enable masks are swept against a set of status patterns. The patterns are single bits, which isolate the interrupt gating per bit. Sparse multi-bit words drive the legacy vector through its lowest-first drain order and show that only the reported bit is cleared. Words with bits above the enable width separate the 5-bit mask from the 6-bit one. Directed sequences cover the rest: a write-one-to-clear landing in the same cycle as a set pulse, with the ready flags in the written word; DMA-enable writes with one or both bits, each checked for the enable bits it clears and the requests it gates; and the forced-set test write with and without its trigger bit. Both modes receive the same stimulus side by side, so any difference in their outputs is traced to the mode.

// File: rtl/intr_unit_pkg.sv
package intr_unit_pkg;
  localparam int DW   = 16;
  localparam int EN_W = 6;

  localparam int B_RRDY    = 3;
  localparam int B_XRDY    = 4;
  localparam int B_BUSY    = 12;
  localparam int B_RX_DMA  = 15;
  localparam int B_TX_DMA  = 7;
  localparam int B_FORCE   = 11;

  localparam logic [DW-1:0] W1C_MASK   = 16'h0027;
  localparam logic [DW-1:0] FORCE_MASK = 16'h003F;
  localparam logic [DW-1:0] DMA_MASK   = 16'h8080;
  localparam logic [DW-1:0] RDY_MASK   = 16'h0018;
  localparam logic [DW-1:0] KEEP_MASK  = ~(16'h0001 << B_BUSY);

  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_EN   = 3'd1,
    SEL_VEC  = 3'd2,
    SEL_DMA  = 3'd3,
    SEL_TEST = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/intr_lowbit_enc.sv
module intr_lowbit_enc #(
  parameter int W = 16,
  localparam int IW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign onehot[i] = vec[i];
    end else begin : g_rest
      assign onehot[i] = vec[i] & ~(|vec[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IW'(i + 1);
    end
  end
endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
  import intr_unit_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt_set,
  input  logic [DW-1:0] clr_mask,
  input  logic [DW-1:0] set_mask,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] evt_eff;
  logic [DW-1:0] stat_nxt;

  assign evt_eff = evt_set & KEEP_MASK;

  always_comb begin
    stat_nxt = stat_q & ~clr_mask;
    stat_nxt = stat_nxt | set_mask;
    stat_nxt = stat_nxt | evt_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt_eff) |=> ((stat_q & $past(evt_eff)) == $past(evt_eff))) // R4
    else $error("set pulse lost");

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_mask & ~evt_eff & ~set_mask)) |=>
      ((stat_q & $past(clr_mask & ~evt_eff & ~set_mask)) == '0)) // R9
    else $error("clear did not take");

  AST_BUSY_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !stat_q[B_BUSY]) // R3
    else $error("busy bit stored");
endmodule

// File: rtl/intr_ctrl_regs.sv
module intr_ctrl_regs
  import intr_unit_pkg::*;
#(
  parameter bit LEGACY = 1'b0,
  localparam logic [EN_W-1:0] EN_MASK = LEGACY ? 6'h1F : 6'h3F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic            dma_wr,
  input  logic [EN_W-1:0] en_wdata,
  input  logic [DW-1:0]   dma_wdata,
  output logic [EN_W-1:0] en_q,
  output logic [DW-1:0]   dma_q
);
  logic [EN_W-1:0] en_nxt;
  logic [DW-1:0]   dma_nxt;

  always_comb begin
    en_nxt  = en_q;
    dma_nxt = dma_q;
    if (en_wr) en_nxt = en_wdata & EN_MASK;
    if (dma_wr) begin
      dma_nxt = dma_wdata & DMA_MASK;
      if (dma_wdata[B_RX_DMA]) en_nxt[B_RRDY] = 1'b0;
      if (dma_wdata[B_TX_DMA]) en_nxt[B_XRDY] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      dma_q <= '0;
    end else begin
      en_q  <= en_nxt;
      dma_q <= dma_nxt;
    end
  end

  AST_RX_DMA_MASKS: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && dma_wdata[B_RX_DMA]) |=> !en_q[B_RRDY]) // R7
    else $error("rx dma did not mask enable");

  AST_TX_DMA_MASKS: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && dma_wdata[B_TX_DMA]) |=> !en_q[B_XRDY]) // R7
    else $error("tx dma did not mask enable");

  AST_DMA_ONLY_TWO: assert property (@(posedge clk) disable iff (rst)
    dma_wr |=> ((dma_q & ~DMA_MASK) == '0)) // R7
    else $error("dma reg stored extra bits");
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_unit_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_sel,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [15:0] evt_set,
  input  logic        line_busy,
  output logic        irq_o,
  output logic        dma_rx_req,
  output logic        dma_tx_req
);
  localparam int IW = $clog2(DW + 1);

  logic [DW-1:0]   stat_q;
  logic [EN_W-1:0] en_q;
  logic [DW-1:0]   dma_q;
  logic [DW-1:0]   pend;
  logic [DW-1:0]   vec_onehot;
  logic [IW-1:0]   vec_idx;
  logic [DW-1:0]   clr_mask;
  logic [DW-1:0]   set_mask;
  logic            stat_wr, en_wr, dma_wr, test_wr, vec_rd;

  assign stat_wr = bus_wr && (bus_sel == SEL_STAT);
  assign en_wr   = bus_wr && (bus_sel == SEL_EN);
  assign dma_wr  = bus_wr && (bus_sel == SEL_DMA);
  assign test_wr = bus_wr && (bus_sel == SEL_TEST);
  assign vec_rd  = bus_rd && (bus_sel == SEL_VEC);

  assign pend = stat_q & {{(DW-EN_W){1'b0}}, en_q};

  intr_lowbit_enc #(.W(DW)) u_enc (
    .vec    (pend),
    .onehot (vec_onehot),
    .idx    (vec_idx)
  );

  if (LEGACY) begin : g_legacy
    assign clr_mask = vec_rd ? vec_onehot : '0;
    assign set_mask = '0;
  end else begin : g_newer
    assign clr_mask = stat_wr ? (bus_wdata & W1C_MASK) : '0;
    assign set_mask = (test_wr && bus_wdata[B_FORCE]) ? FORCE_MASK : '0;
  end

  intr_status_reg u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt_set  (evt_set),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .stat_q   (stat_q)
  );

  intr_ctrl_regs #(.LEGACY(LEGACY)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en_wr     (en_wr),
    .dma_wr    (dma_wr),
    .en_wdata  (bus_wdata[EN_W-1:0]),
    .dma_wdata (bus_wdata),
    .en_q      (en_q),
    .dma_q     (dma_q)
  );

  assign irq_o      = |pend;
  assign dma_rx_req = dma_q[B_RX_DMA] & stat_q[B_RRDY];
  assign dma_tx_req = dma_q[B_TX_DMA] & stat_q[B_XRDY];

  always_comb begin
    unique case (bus_sel)
      SEL_STAT: bus_rdata = stat_q | (DW'(line_busy) << B_BUSY);
      SEL_EN:   bus_rdata = {{(DW-EN_W){1'b0}}, en_q};
      SEL_VEC:  bus_rdata = LEGACY ? {{(DW-IW){1'b0}}, vec_idx} : '0;
      SEL_DMA:  bus_rdata = dma_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (!irq_o && !dma_rx_req && !dma_tx_req)) // R1
    else $error("outputs active after reset");

  AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_onehot)) // R9
    else $error("vector select not onehot");

  AST_RDY_NOT_W1C: assert property (@(posedge clk) disable iff (rst)
    (!LEGACY && stat_wr) |=>
      (((stat_q & RDY_MASK) & $past(stat_q & RDY_MASK)) == $past(stat_q & RDY_MASK))) // R5
    else $error("ready flag cleared by write");
endmodule

// File: tb/intr_status_unit_tb.sv
module intr_status_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0, busy = 1'b0;
  logic [2:0]  sel = '0;
  logic [15:0] wd = '0, ev = '0;
  logic [15:0] rdata [2];
  logic        irq [2], drx [2], dtx [2];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] m_stat [2];
  logic [5:0]  m_en   [2];
  logic [15:0] m_dma  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_status_unit #(.LEGACY(1'b0)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_sel(sel),
    .bus_wdata(wd), .bus_rdata(rdata[0]), .evt_set(ev), .line_busy(busy),
    .irq_o(irq[0]), .dma_rx_req(drx[0]), .dma_tx_req(dtx[0]));

  intr_status_unit #(.LEGACY(1'b1)) u_dut_leg (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_sel(sel),
    .bus_wdata(wd), .bus_rdata(rdata[1]), .evt_set(ev), .line_busy(busy),
    .irq_o(irq[1]), .dma_rx_req(drx[1]), .dma_tx_req(dtx[1]));

  function automatic logic [15:0] ffs16(logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  function automatic logic [15:0] exp_rd(int k, logic [2:0] s);
    case (s)
      3'd0: return m_stat[k] | (16'(busy) << 12);
      3'd1: return {10'b0, m_en[k]};
      3'd2: return (k == 1) ? ffs16(m_stat[k] & {10'b0, m_en[k]}) : 16'd0;
      3'd3: return m_dma[k];
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string req, int k, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s mode=%0s actual=%h expected=%h", req,
               (k == 1) ? "legacy" : "newer", act, exp);
    end
  endtask

  task automatic model_step(int k, bit w, bit r, logic [2:0] s,
                            logic [15:0] d, logic [15:0] e);
    logic [15:0] ns, nd, v;
    logic [5:0]  ne;
    bit leg;
    leg = (k == 1);
    ns = m_stat[k]; ne = m_en[k]; nd = m_dma[k];
    if (w) begin
      case (s)
        3'd0: if (!leg) ns = ns & ~(d & 16'h0027);
        3'd1: ne = d[5:0] & (leg ? 6'h1F : 6'h3F);
        3'd3: begin
          nd = d & 16'h8080;
          if (d[15]) ne[3] = 1'b0;
          if (d[7])  ne[4] = 1'b0;
        end
        3'd4: if (!leg && d[11]) ns = ns | 16'h003F;
        default: ;
      endcase
    end
    if (r && s == 3'd2 && leg) begin
      v = ffs16(m_stat[k] & {10'b0, m_en[k]});
      if (v != 0) ns[v-1] = 1'b0;
    end
    ns = ns | (e & 16'hEFFF);
    m_stat[k] = ns; m_en[k] = ne; m_dma[k] = nd;
  endtask

  task automatic check_outs();
    for (int k = 0; k < 2; k++) begin
      check("R2", k, 16'(irq[k]), 16'(|(m_stat[k] & {10'b0, m_en[k]})));
      check("R8", k, 16'(drx[k]), 16'(m_stat[k][3] & m_dma[k][15]));
      check("R8", k, 16'(dtx[k]), 16'(m_stat[k][4] & m_dma[k][7]));
    end
  endtask

  task automatic op(bit w, bit r, logic [2:0] s, logic [15:0] d,
                    logic [15:0] e, string req);
    @(negedge clk);
    check_outs();
    wr = w; rd = r; sel = s; wd = d; ev = e;
    #1;
    for (int k = 0; k < 2; k++) begin
      if (r) check(req, k, rdata[k], exp_rd(k, s));
      model_step(k, w, r, s, d, e);
    end
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr = 1'b0; rd = 1'b0; ev = '0;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      m_stat[k] = '0; m_en[k] = '0; m_dma[k] = '0;
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [8];
    pats = '{16'h0002, 16'h0004, 16'h0008, 16'h0010,
             16'h0021, 16'h0C1E, 16'h8000, 16'h103F};
    do_reset();
    do_reset();
    // R1: every register reads zero after reset
    for (int s = 0; s < 5; s++) op(1'b0, 1'b1, 3'(s), 16'h0, 16'h0, "R1");

    // R3: busy reflected in bit 12
    busy = 1'b1;
    op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R3");
    busy = 1'b0;
    op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R3");

    // R6 / R2 / R9 sweep over all enable masks and status patterns
    for (int e = 0; e < 64; e++) begin
      for (int p = 0; p < 8; p++) begin
        do_reset();
        op(1'b1, 1'b0, 3'd1, 16'(e) | 16'hFFC0, 16'h0, "");
        op(1'b0, 1'b1, 3'd1, 16'h0, pats[p], "R6");
        op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R4");
        for (int n = 0; n < 6; n++) op(1'b0, 1'b1, 3'd2, 16'h0, 16'h0, "R9");
        op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R9");
      end
    end

    // R5: write-one-to-clear with a same-cycle set pulse on bit 1
    do_reset();
    op(1'b0, 1'b0, 3'd0, 16'h0, 16'h8C3F, "");
    op(1'b1, 1'b0, 3'd0, 16'hFFFF, 16'h0002, "");
    op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R5");
    op(1'b1, 1'b0, 3'd0, 16'h0018, 16'h0, "");
    op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R5");

    // R7 / R8: DMA-enable register
    do_reset();
    op(1'b1, 1'b0, 3'd1, 16'h003F, 16'h0, "");
    op(1'b1, 1'b0, 3'd3, 16'hFFFF, 16'h0018, "");
    op(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, "R7");
    op(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, "R7");
    op(1'b1, 1'b0, 3'd3, 16'h8000, 16'h0, "");
    op(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, "R7");
    op(1'b1, 1'b0, 3'd3, 16'h0080, 16'h0, "");
    op(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, "R8");
    op(1'b1, 1'b0, 3'd3, 16'h0000, 16'h0, "");
    do_reset();
    op(1'b1, 1'b0, 3'd1, 16'h003F, 16'h0, "");
    op(1'b1, 1'b0, 3'd3, 16'h0080, 16'h0, "");
    op(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, "R7");
    op(1'b1, 1'b0, 3'd3, 16'h8000, 16'h0, "");
    op(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, "R7");

    // R10: forced set through the test select
    do_reset();
    op(1'b1, 1'b0, 3'd1, 16'h003F, 16'h0, "");
    op(1'b1, 1'b0, 3'd4, 16'hF7FF, 16'h0, "");
    op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R10");
    op(1'b1, 1'b0, 3'd4, 16'h0800, 16'h0, "");
    op(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, "R10");
    op(1'b0, 1'b1, 3'd4, 16'h0, 16'h0, "R10");
    op(1'b0, 1'b1, 3'd7, 16'h0, 16'h0, "R10");

    @(negedge clk);
    check_outs();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule